// File: doc/BRIEF.md
# Load-Scaled Memory Channel Affinity Unit

This unit keeps, for each of four memory channels, a fixed suitability score for reads and another for writes. Each score expresses how fast that channel's memory is compared with the fastest memory installed. It is the shortest latency among the installed memories divided by the channel's own latency, written in hundredths (latencies of 15, 20, 60 and 150 ns give 100, 75, 25 and 10). Configuration writes load these fixed scores.

At run time the unit scales each fixed score down by how busy the matching request queue is. The read score is multiplied by the fraction of free read-queue slots, and the write score by the fraction of free write-queue slots. The result is an effective score that a placement engine can compare across channels.

Alongside the scores, the unit keeps the row most recently opened in every bank of every channel. This lets a requester ask, before issuing a write, whether that write would land in an already open row.

Top module: `chan_affinity_unit`

## Requirements
- R1: After reset every fixed and effective score reads 100, and no bank holds a recorded row, so every lookup reports a miss.
- R2: A configuration write with `cfg_sel_wr`=0 loads the read score of channel `cfg_ch`, and with `cfg_sel_wr`=1 loads its write score. The other score of that channel and all other channels keep their values.
- R3: A configured score above 100 is stored as 100. Stored scores never exceed 100.
- R4: On every clock edge each effective score is registered as floor(fixed × (64 − occupancy) / 64). The calculation uses the fixed score held before that edge and the occupancy present at the edge. Read scores use the read occupancy and write scores use the write occupancy. Channel c occupies bits [7c+6:7c] of each flattened score and occupancy bus.
- R5: An occupancy of 64 or more is treated as a full queue and gives an effective score of 0.
- R6: `look_hit` is 1 exactly when the addressed channel and bank hold a recorded row equal to `look_row`. It follows the lookup pins combinationally.
- R7: An activate records `act_row` for its own channel and bank only. A later activate to the same bank replaces the earlier row.
- R8: An activate is visible to lookups only after the clock edge that captures it, not during the cycle in which it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load a fixed score |
| cfg_ch | input | 2 | Channel of the configuration write |
| cfg_sel_wr | input | 1 | 0 selects the read score, 1 selects the write score |
| cfg_score | input | 7 | Fixed score in hundredths |
| rd_occ | input | 28 | Read-queue occupancy per channel, 7 bits each |
| wr_occ | input | 28 | Write-queue occupancy per channel, 7 bits each |
| act_valid | input | 1 | A row activate is reported |
| act_ch | input | 2 | Channel of the activate |
| act_bank | input | 3 | Bank of the activate |
| act_row | input | 16 | Row opened |
| look_ch | input | 2 | Channel to look up |
| look_bank | input | 3 | Bank to look up |
| look_row | input | 16 | Row to compare |
| look_hit | output | 1 | The lookup row is the open row |
| eff_rd_score | output | 28 | Effective read score per channel, 7 bits each |
| eff_wr_score | output | 28 | Effective write score per channel, 7 bits each |

## Verification
The assertions check on every cycle that fixed scores stay within 100 and change only under a configuration write for their channel. They also check that an effective score never exceeds the fixed score it came from, that an empty queue passes the fixed score through, and that a full queue forces zero. For the row table they check that the table holds still without an activate and that a just-recorded row hits. Only the bench scenarios can show the exact truncated products such as 56 for 75 at 16 entries, the separation between channels and between read and write scores, the saturation of oversized writes, and the one-edge delay before an activate becomes visible.

// File: rtl/aff_pkg.sv
package aff_pkg;
    localparam int SCORE_W    = 7;
    localparam int SCORE_FULL = 100;

    function automatic logic [SCORE_W-1:0] clamp_score(input logic [SCORE_W-1:0] raw);
        return (raw > SCORE_W'(SCORE_FULL)) ? SCORE_W'(SCORE_FULL) : raw;
    endfunction
endpackage

// File: rtl/aff_derate.sv
module aff_derate #(
    parameter int SCORE_W = 7,
    parameter int QDEPTH  = 64,
    parameter int OCC_W   = $clog2(QDEPTH + 1)
) (
    input  logic [SCORE_W-1:0] score_in,
    input  logic [OCC_W-1:0]   occ,
    output logic [SCORE_W-1:0] score_out
);
    localparam int PW = SCORE_W + OCC_W;

    logic [OCC_W-1:0] free_slots;
    logic [PW-1:0]    product;
    logic [PW-1:0]    quotient;

    always_comb begin
        free_slots = (occ >= OCC_W'(QDEPTH)) ? '0 : OCC_W'(QDEPTH) - occ;
        product    = PW'(score_in) * PW'(free_slots);
        quotient   = product / PW'(QDEPTH);
        score_out  = quotient[SCORE_W-1:0];
    end
endmodule

// File: rtl/aff_score_chan.sv
module aff_score_chan
    import aff_pkg::*;
#(
    parameter int QDEPTH = 64,
    parameter int OCC_W  = $clog2(QDEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_hit,
    input  logic               cfg_sel_wr,
    input  logic [SCORE_W-1:0] cfg_score,
    input  logic [OCC_W-1:0]   rd_occ,
    input  logic [OCC_W-1:0]   wr_occ,
    output logic [SCORE_W-1:0] eff_rd,
    output logic [SCORE_W-1:0] eff_wr
);
    typedef struct packed {
        logic [SCORE_W-1:0] fix_rd;
        logic [SCORE_W-1:0] fix_wr;
        logic [SCORE_W-1:0] eff_rd;
        logic [SCORE_W-1:0] eff_wr;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [SCORE_W-1:0] scaled_rd, scaled_wr;

    aff_derate #(.SCORE_W(SCORE_W), .QDEPTH(QDEPTH), .OCC_W(OCC_W)) u_rd_scale (
        .score_in (st_q.fix_rd),
        .occ      (rd_occ),
        .score_out(scaled_rd)
    );

    aff_derate #(.SCORE_W(SCORE_W), .QDEPTH(QDEPTH), .OCC_W(OCC_W)) u_wr_scale (
        .score_in (st_q.fix_wr),
        .occ      (wr_occ),
        .score_out(scaled_wr)
    );

    always_comb begin
        st_d        = st_q;
        st_d.eff_rd = scaled_rd;
        st_d.eff_wr = scaled_wr;
        if (cfg_hit) begin
            if (cfg_sel_wr) st_d.fix_wr = clamp_score(cfg_score);
            else            st_d.fix_rd = clamp_score(cfg_score);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fix_rd <= SCORE_W'(SCORE_FULL);
            st_q.fix_wr <= SCORE_W'(SCORE_FULL);
            st_q.eff_rd <= SCORE_W'(SCORE_FULL);
            st_q.eff_wr <= SCORE_W'(SCORE_FULL);
        end else begin
            st_q <= st_d;
        end
    end

    assign eff_rd = st_q.eff_rd;
    assign eff_wr = st_q.eff_wr;

    // R3
    fixed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fix_rd <= SCORE_W'(SCORE_FULL)) && (st_q.fix_wr <= SCORE_W'(SCORE_FULL)));

    // R2
    fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hit |=> ($stable(st_q.fix_rd) && $stable(st_q.fix_wr)));

    // R4
    eff_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.eff_rd <= $past(st_q.fix_rd)) && (st_q.eff_wr <= $past(st_q.fix_wr))));

    // R4
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_occ == '0) |=> (st_q.eff_rd == $past(st_q.fix_rd)));

    // R5
    full_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_occ >= OCC_W'(QDEPTH)) || (wr_occ >= OCC_W'(QDEPTH))) |=>
        (($past(rd_occ) < OCC_W'(QDEPTH)) || (st_q.eff_rd == '0)) &&
        (($past(wr_occ) < OCC_W'(QDEPTH)) || (st_q.eff_wr == '0)));
endmodule

// File: rtl/aff_row_table.sv
module aff_row_table #(
    parameter int NUM_CH   = 4,
    parameter int NUM_BANK = 8,
    parameter int ROW_W    = 16,
    parameter int CH_W     = $clog2(NUM_CH),
    parameter int BK_W     = $clog2(NUM_BANK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid,
    input  logic [CH_W-1:0]  act_ch,
    input  logic [BK_W-1:0]  act_bank,
    input  logic [ROW_W-1:0] act_row,
    input  logic [CH_W-1:0]  look_ch,
    input  logic [BK_W-1:0]  look_bank,
    input  logic [ROW_W-1:0] look_row,
    output logic             look_hit
);
    localparam int ENTRIES = NUM_CH * NUM_BANK;
    localparam int IDX_W   = CH_W + BK_W;

    typedef struct packed {
        logic [ENTRIES-1:0][ROW_W-1:0] row;
        logic [ENTRIES-1:0]            vld;
    } tab_state_t;

    tab_state_t tab_d, tab_q;
    logic [IDX_W-1:0] act_idx, look_idx;

    always_comb begin
        act_idx  = {act_ch, act_bank};
        look_idx = {look_ch, look_bank};
        tab_d    = tab_q;
        if (act_valid) begin
            tab_d.row[act_idx] = act_row;
            tab_d.vld[act_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    assign look_hit = tab_q.vld[look_idx] && (tab_q.row[look_idx] == look_row);

    // R7
    table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_valid |=> ($stable(tab_q.row) && $stable(tab_q.vld)));

    // R6
    fresh_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |=> (!((look_ch == $past(act_ch)) && (look_bank == $past(act_bank)) &&
                         (look_row == $past(act_row))) || look_hit));
endmodule

// File: rtl/chan_affinity_unit.sv
module chan_affinity_unit
    import aff_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int NUM_BANK = 8,
    parameter int ROW_W    = 16,
    parameter int QDEPTH   = 64,
    parameter int CH_W     = $clog2(NUM_CH),
    parameter int BK_W     = $clog2(NUM_BANK),
    parameter int OCC_W    = $clog2(QDEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [CH_W-1:0]           cfg_ch,
    input  logic                      cfg_sel_wr,
    input  logic [SCORE_W-1:0]        cfg_score,
    input  logic [NUM_CH*OCC_W-1:0]   rd_occ,
    input  logic [NUM_CH*OCC_W-1:0]   wr_occ,
    input  logic                      act_valid,
    input  logic [CH_W-1:0]           act_ch,
    input  logic [BK_W-1:0]           act_bank,
    input  logic [ROW_W-1:0]          act_row,
    input  logic [CH_W-1:0]           look_ch,
    input  logic [BK_W-1:0]           look_bank,
    input  logic [ROW_W-1:0]          look_row,
    output logic                      look_hit,
    output logic [NUM_CH*SCORE_W-1:0] eff_rd_score,
    output logic [NUM_CH*SCORE_W-1:0] eff_wr_score
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic cfg_hit;
        assign cfg_hit = cfg_we && (cfg_ch == CH_W'(c));

        aff_score_chan #(.QDEPTH(QDEPTH), .OCC_W(OCC_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_hit   (cfg_hit),
            .cfg_sel_wr(cfg_sel_wr),
            .cfg_score (cfg_score),
            .rd_occ    (rd_occ[c*OCC_W +: OCC_W]),
            .wr_occ    (wr_occ[c*OCC_W +: OCC_W]),
            .eff_rd    (eff_rd_score[c*SCORE_W +: SCORE_W]),
            .eff_wr    (eff_wr_score[c*SCORE_W +: SCORE_W])
        );
    end

    aff_row_table #(
        .NUM_CH(NUM_CH), .NUM_BANK(NUM_BANK), .ROW_W(ROW_W), .CH_W(CH_W), .BK_W(BK_W)
    ) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_valid(act_valid),
        .act_ch   (act_ch),
        .act_bank (act_bank),
        .act_row  (act_row),
        .look_ch  (look_ch),
        .look_bank(look_bank),
        .look_row (look_row),
        .look_hit (look_hit)
    );
endmodule

// File: tb/chan_affinity_unit_test.sv
`timescale 1ns/1ps
module chan_affinity_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic        cfg_sel_wr = 1'b0;
    logic [6:0]  cfg_score = '0;
    logic [27:0] rd_occ = '0;
    logic [27:0] wr_occ = '0;
    logic        act_valid = 1'b0;
    logic [1:0]  act_ch = '0;
    logic [2:0]  act_bank = '0;
    logic [15:0] act_row = '0;
    logic [1:0]  look_ch = '0;
    logic [2:0]  look_bank = '0;
    logic [15:0] look_row = '0;
    logic        look_hit;
    logic [27:0] eff_rd_score, eff_wr_score;

    int checks = 0;
    int failures = 0;
    bit reported = 0;

    chan_affinity_unit uut (.*);

    always #2.5 clk = ~clk;

    // behavioural reference state
    int m_fix_rd[4], m_fix_wr[4], m_eff_rd[4], m_eff_wr[4];
    int m_row[4][8];
    bit m_vld[4][8];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    endtask

    function automatic int scale(input int s, input int o);
        int f;
        f = (o >= 64) ? 0 : 64 - o;
        return (s * f) / 64;
    endfunction

    function automatic int fld(input logic [27:0] v, input int c);
        return int'(v[c*7 +: 7]);
    endfunction

    function automatic int exp_hit();
        return (m_vld[look_ch][look_bank] && m_row[look_ch][look_bank] == int'(look_row)) ? 1 : 0;
    endfunction

    // reference update on each edge, then compare shortly after
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_fix_rd[c] = 100; m_fix_wr[c] = 100;
                m_eff_rd[c] = 100; m_eff_wr[c] = 100;
                for (int b = 0; b < 8; b++) begin m_row[c][b] = 0; m_vld[c][b] = 0; end
            end
        end else begin
            for (int c = 0; c < 4; c++) begin
                m_eff_rd[c] = scale(m_fix_rd[c], fld(rd_occ, c));
                m_eff_wr[c] = scale(m_fix_wr[c], fld(wr_occ, c));
            end
            if (cfg_we) begin
                if (cfg_sel_wr) m_fix_wr[cfg_ch] = (cfg_score > 100) ? 100 : int'(cfg_score);
                else            m_fix_rd[cfg_ch] = (cfg_score > 100) ? 100 : int'(cfg_score);
            end
            if (act_valid) begin
                m_row[act_ch][act_bank] = int'(act_row);
                m_vld[act_ch][act_bank] = 1;
            end
            #1;
            for (int c = 0; c < 4; c++) begin
                chk("R4 eff read", fld(eff_rd_score, c), m_eff_rd[c]);
                chk("R4 eff write", fld(eff_wr_score, c), m_eff_wr[c]);
            end
            chk("R6 lookup", int'(look_hit), exp_hit());
        end
    end

    task automatic idle();
        @(negedge clk);
        cfg_we = 0; act_valid = 0;
    endtask

    task automatic cfg(input int ch, input bit w, input int s);
        @(negedge clk);
        cfg_we = 1; cfg_ch = 2'(ch); cfg_sel_wr = w; cfg_score = 7'(s); act_valid = 0;
    endtask

    task automatic settle();
        @(posedge clk); #2;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle();
        // R1: reset state
        for (int c = 0; c < 4; c++) begin
            chk("R1 reset eff read", fld(eff_rd_score, c), 100);
            chk("R1 reset eff write", fld(eff_wr_score, c), 100);
        end
        chk("R1 reset lookup row 0", int'(look_hit), 0);

        // R2: load channel 0 read score only
        cfg(0, 0, 75);
        idle(); settle();
        chk("R2 ch0 read", fld(eff_rd_score, 0), 75);
        chk("R2 ch0 write untouched", fld(eff_wr_score, 0), 100);
        chk("R2 ch1 read untouched", fld(eff_rd_score, 1), 100);

        // R3: saturation
        cfg(1, 1, 30);
        cfg(1, 1, 120);
        idle(); settle();
        chk("R3 saturated write", fld(eff_wr_score, 1), 100);
        chk("R2 ch1 read untouched", fld(eff_rd_score, 1), 100);

        // R4: derating
        @(negedge clk);
        rd_occ[0*7 +: 7] = 7'd16;
        wr_occ[2*7 +: 7] = 7'd63;
        settle();
        chk("R4 75 at 16 of 64", fld(eff_rd_score, 0), 56);
        chk("R4 100 at 63 of 64", fld(eff_wr_score, 2), 1);
        chk("R4 write uses write occupancy", fld(eff_wr_score, 0), 100);

        // R5: full and over-full queues
        @(negedge clk);
        rd_occ[3*7 +: 7] = 7'd64;
        wr_occ[3*7 +: 7] = 7'd90;
        settle();
        chk("R5 read full", fld(eff_rd_score, 3), 0);
        chk("R5 write over full", fld(eff_wr_score, 3), 0);
        @(negedge clk);
        rd_occ = '0; wr_occ = '0;

        // R8 / R6: activate visibility
        @(negedge clk);
        act_valid = 1; act_ch = 2'd1; act_bank = 3'd3; act_row = 16'hABCD;
        look_ch = 2'd1; look_bank = 3'd3; look_row = 16'hABCD;
        #1;
        chk("R8 not visible before edge", int'(look_hit), 0);
        settle();
        chk("R6 hit after activate", int'(look_hit), 1);
        idle();
        look_bank = 3'd4; #1;
        chk("R7 other bank miss", int'(look_hit), 0);
        look_ch = 2'd2; look_bank = 3'd3; #1;
        chk("R7 other channel miss", int'(look_hit), 0);
        look_ch = 2'd1; look_row = 16'hABCC; #1;
        chk("R6 different row miss", int'(look_hit), 0);

        @(negedge clk);
        act_valid = 1; act_ch = 2'd1; act_bank = 3'd4; act_row = 16'h1111;
        look_row = 16'hABCD;
        settle();
        chk("R7 neighbour activate keeps row", int'(look_hit), 1);
        @(negedge clk);
        act_valid = 1; act_ch = 2'd1; act_bank = 3'd3; act_row = 16'h2222;
        settle();
        chk("R7 replaced row misses", int'(look_hit), 0);
        idle();
        look_row = 16'h2222; #1;
        chk("R7 new row hits", int'(look_hit), 1);

        // mixed traffic against the reference
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            cfg_we     = ($urandom % 6) == 0;
            cfg_ch     = 2'($urandom);
            cfg_sel_wr = 1'($urandom);
            cfg_score  = 7'($urandom);
            for (int c = 0; c < 4; c++) begin
                rd_occ[c*7 +: 7] = 7'($urandom % 72);
                wr_occ[c*7 +: 7] = 7'($urandom % 72);
            end
            act_valid = ($urandom % 3) == 0;
            act_ch    = 2'($urandom);
            act_bank  = 3'($urandom);
            act_row   = 16'($urandom % 4);
            look_ch   = 2'($urandom);
            look_bank = 3'($urandom);
            look_row  = 16'($urandom % 4);
        end
        idle();
        settle();
        report();
    end
endmodule